// File: doc/BRIEF.md
# Serially Controlled Core Test Wrapper

This block sits around a small embedded core and gives test equipment access to the core's terminals through a serial port. The port has one serial data input, one serial data output and a group of control strobes that act directly on the wrapper. There is no decoding state machine. Inside the wrapper are three registers: a 3-bit instruction register, a one-bit bypass register, and a boundary register with one cell for every core input and every core output.

The active instruction does two things. It decides which register is connected between serial in and serial out, and it sets the mode of every boundary cell. In functional operation the wrapper is transparent, so host logic reaches the core inputs and the core outputs reach the host. In internal test, the core is fed from stored cell values and its responses are captured. In external test, the host-side wiring is driven from stored values and the values arriving from the host are captured.

Each cell has two stages: a shift stage and an update stage. A pattern can therefore be shifted in without disturbing the values being driven. The pattern takes effect on an explicit update strobe.

Top module: `core_test_wrapper`

## Requirements
- R1: After the active-low reset, the active instruction is bypass (000), every update stage holds 0, the bypass register holds 0, and both directions pass straight through.
- R2: While `sel_ir` is high, shift moves the instruction shift stage one place per clock, least significant bit first, and `so` shows its bit 0. Capture loads the active instruction into the shift stage. Update makes the shift stage the active instruction. Without an update, the active instruction never changes.
- R3: Under bypass, preload and the unused codes, `core_in` equals `host_in` and `host_out` equals `core_out`.
- R4: The codes are 000 bypass, 001 external test, 010 internal test and 011 preload. Codes 100 to 111 behave exactly like bypass.
- R5: When the bypass register is selected, `so` is `si` delayed by one shift clock, and a capture loads 0 into it.
- R6: The boundary path has `N_IN+N_OUT` cells. Cell 0, nearest `so`, is core input 0. The input cells come first, then the output cells. The first bit shifted in ends in the last cell reached, so after a full load bit k of the pattern sits in cell k.
- R7: Under external test, `host_out` is driven from the output cells' update stages, and a capture loads `host_in` into the input cells' shift stages. The output cells hold their values during that capture.
- R8: Under internal test, `core_in` is driven from the input cells' update stages, and a capture loads `core_out` into the output cells' shift stages. The input cells hold their values during that capture.
- R9: Under preload, the boundary register shifts and updates, but the terminals stay transparent and a capture changes nothing. The preloaded values are driven as soon as an external-test instruction becomes active.
- R10: Shifting and capturing never change `core_in` or `host_out`. Only an update of a test-mode instruction does.
- R11: When capture and shift are both high, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Wrapper clock |
| wrst_n | input | 1 | Asynchronous active-low reset |
| sel_ir | input | 1 | Selects the instruction register for capture, shift and update |
| shift_en | input | 1 | Shift strobe |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| host_in | input | N_IN | Host logic values meant for the core inputs |
| core_in | output | N_IN | Values applied to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| host_out | output | N_OUT | Values presented to the host logic |

## Verification
The hardest situation to reach is the hand-off between instructions that share boundary state. One example is a pattern loaded under preload and then driven only after the instruction changes to external test. Another is update-stage values left over from one test mode that must persist while another mode is loaded. The bench gets there by chaining its scenarios without any reset in between, so each one inherits the cell contents of the previous one. It also reads the instruction back through a capture without an update, to show that the active mode survives a readback.

// File: rtl/ctw_pkg.sv
package ctw_pkg;
    localparam int IR_W = 3;

    typedef enum logic [IR_W-1:0] {
        I_BYPASS = 3'b000,
        I_EXT    = 3'b001,
        I_INT    = 3'b010,
        I_PRE    = 3'b011
    } instr_e;

    typedef struct packed {
        logic ext;      // output side driven from update stage
        logic intl;     // input side driven from update stage
        logic bnd_sel;  // boundary register on the serial path
    } mode_t;
endpackage

// File: rtl/ctw_ir.sv
module ctw_ir
    import ctw_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel,
    input  logic  shift,
    input  logic  capture,
    input  logic  update,
    input  logic  si,
    output logic  so_ir,
    output mode_t mode
);
    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic [IR_W-1:0] act;
    } ir_st_t;

    ir_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (capture)
                st_d.sh = st_q.act;
            else if (shift)
                st_d.sh = {si, st_q.sh[IR_W-1:1]};
            if (update)
                st_d.act = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '0;
            st_q.act <= I_BYPASS;
        end else begin
            st_q <= st_d;
        end
    end

    assign so_ir = st_q.sh[0];

    // unused codes fall back to bypass (R4)
    always_comb begin
        mode = '0;
        case (st_q.act)
            I_EXT:   begin mode.ext  = 1'b1; mode.bnd_sel = 1'b1; end
            I_INT:   begin mode.intl = 1'b1; mode.bnd_sel = 1'b1; end
            I_PRE:   mode.bnd_sel = 1'b1;
            default: mode = '0;
        endcase
    end

    p_ir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && update) |=> $stable(st_q.act));

    p_ir_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture) |=> (st_q.sh[IR_W-1] == $past(si)));
endmodule

// File: rtl/ctw_bypass.sv
module ctw_bypass (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic shift,
    input  logic capture,
    input  logic si,
    output logic so_byp
);
    typedef struct packed {
        logic bit0;
    } byp_st_t;

    byp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel) begin
            if (capture)
                st_d.bit0 = 1'b0;
            else if (shift)
                st_d.bit0 = si;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign so_byp = st_q.bit0;

    p_bypass_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !capture) |=> (so_byp == $past(si)));

    p_bypass_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && capture) |=> (so_byp == 1'b0));
endmodule

// File: rtl/ctw_bcell.sv
module ctw_bcell (
    input  logic clk,
    input  logic rst_n,
    input  logic sh_en,
    input  logic cap_en,
    input  logic upd_en,
    input  logic use_upd,
    input  logic scan_in,
    input  logic func_in,
    output logic scan_out,
    output logic func_out
);
    typedef struct packed {
        logic sh;
        logic upd;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_en)
            st_d.sh = func_in;
        else if (sh_en)
            st_d.sh = scan_in;
        if (upd_en)
            st_d.upd = st_q.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign scan_out = st_q.sh;
    assign func_out = use_upd ? st_q.upd : func_in;

    // driven value only moves on update (R10)
    p_hold_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(st_q.upd));
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
    import ctw_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_OUT = 4
) (
    input  logic             wclk,
    input  logic             wrst_n,
    input  logic             sel_ir,
    input  logic             shift_en,
    input  logic             capture_en,
    input  logic             update_en,
    input  logic             si,
    output logic             so,
    input  logic [N_IN-1:0]  host_in,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_OUT-1:0] core_out,
    output logic [N_OUT-1:0] host_out
);
    localparam int LEN = N_IN + N_OUT;

    mode_t      mode;
    logic       ir_so, byp_so;
    logic       cap_g, sh_g, up_g, byp_sel;
    logic [LEN:0] link;

    ctw_ir u_ir (
        .clk(wclk), .rst_n(wrst_n), .sel(sel_ir), .shift(shift_en),
        .capture(capture_en), .update(update_en), .si(si),
        .so_ir(ir_so), .mode(mode)
    );

    assign byp_sel = !sel_ir && !mode.bnd_sel;

    ctw_bypass u_byp (
        .clk(wclk), .rst_n(wrst_n), .sel(byp_sel), .shift(shift_en),
        .capture(capture_en), .si(si), .so_byp(byp_so)
    );

    // boundary strobes: capture wins over shift (R11)
    assign cap_g = capture_en && !sel_ir && mode.bnd_sel;
    assign sh_g  = shift_en && !capture_en && !sel_ir && mode.bnd_sel;
    assign up_g  = update_en && !sel_ir && mode.bnd_sel;

    assign link[LEN] = si;

    generate
        for (genvar k = 0; k < N_IN; k++) begin : g_in
            ctw_bcell u_cell (
                .clk(wclk), .rst_n(wrst_n),
                .sh_en(sh_g), .cap_en(cap_g && mode.ext), .upd_en(up_g),
                .use_upd(mode.intl),
                .scan_in(link[k+1]), .func_in(host_in[k]),
                .scan_out(link[k]), .func_out(core_in[k])
            );
        end
        for (genvar j = 0; j < N_OUT; j++) begin : g_out
            ctw_bcell u_cell (
                .clk(wclk), .rst_n(wrst_n),
                .sh_en(sh_g), .cap_en(cap_g && mode.intl), .upd_en(up_g),
                .use_upd(mode.ext),
                .scan_in(link[N_IN+j+1]), .func_in(core_out[j]),
                .scan_out(link[N_IN+j]), .func_out(host_out[j])
            );
        end
    endgenerate

    assign so = sel_ir ? ir_so : (mode.bnd_sel ? link[0] : byp_so);

    // a full boundary shift moves si toward so one cell per clock (R6)
    p_chain_tail_r6: assert property (@(posedge wclk) disable iff (!wrst_n)
        sh_g |=> (link[LEN-1] == $past(si)));
endmodule

// File: tb/sim_core_test_wrapper.sv
module sim_core_test_wrapper;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_ir = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0;
    logic       si = 1'b0;
    logic       so;
    logic [3:0] host_in = 4'h0, core_in, core_out = 4'h0, host_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    core_test_wrapper #(.N_IN(4), .N_OUT(4)) u0 (
        .wclk(clk), .wrst_n(rst_n), .sel_ir(sel_ir), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .si(si), .so(so),
        .host_in(host_in), .core_in(core_in), .core_out(core_out), .host_out(host_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // every task starts and ends at a falling edge
    task automatic load_ir(input logic [2:0] code);
        sel_ir = 1'b1; shift_en = 1'b1;
        for (int i = 0; i < 3; i++) begin si = code[i]; @(negedge clk); end
        shift_en = 1'b0; update_en = 1'b1;
        @(negedge clk);
        update_en = 1'b0; sel_ir = 1'b0;
    endtask

    task automatic read_ir(output logic [2:0] got);
        sel_ir = 1'b1; capture_en = 1'b1;
        @(negedge clk);
        capture_en = 1'b0; shift_en = 1'b1;
        for (int i = 0; i < 3; i++) begin si = 1'b0; got[i] = so; @(negedge clk); end
        shift_en = 1'b0; sel_ir = 1'b0;
    endtask

    task automatic shift_dr(input logic [7:0] v, output logic [7:0] got);
        shift_en = 1'b1;
        for (int i = 0; i < 8; i++) begin si = v[i]; got[i] = so; @(negedge clk); end
        shift_en = 1'b0;
    endtask

    task automatic pulse_cap();
        capture_en = 1'b1; @(negedge clk); capture_en = 1'b0;
    endtask

    task automatic pulse_upd();
        update_en = 1'b1; @(negedge clk); update_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [2:0] ir;
        host_in = 4'h6; core_out = 4'h9;
        @(negedge clk);
        check("R1 core_in pass", core_in, 4'h6);
        check("R1 host_out pass", host_out, 4'h9);
        check("R1 bypass so", so, 1'b0);
        read_ir(ir);
        check("R1 R2 instr after reset", ir, 3'b000);
    endtask

    task automatic t_bypass();
        logic [7:0] got;
        shift_dr(8'b1011_0110, got);
        check("R5 bypass first bit", got[0], 1'b0);
        check("R5 bypass delay", got[7:1], 7'b011_0110);
        check("R5 bypass holds last", so, 1'b1);
        pulse_cap();
        check("R5 capture zero", so, 1'b0);
        check("R3 bypass core_in", core_in, host_in);
        check("R3 bypass host_out", host_out, core_out);
    endtask

    task automatic t_extest();
        logic [2:0] ir;
        logic [7:0] got;
        load_ir(3'b001);
        read_ir(ir);
        check("R2 readback ext", ir, 3'b001);
        host_in = 4'hA; core_out = 4'h5;
        @(negedge clk);
        check("R7 host_out from stage", host_out, 4'h0);
        shift_dr(8'hC3, got);
        check("R10 shift keeps host_out", host_out, 4'h0);
        pulse_upd();
        check("R7 R2 host_out driven", host_out, 4'hC);
        check("R7 core_in transparent", core_in, 4'hA);
        pulse_cap();
        check("R10 capture keeps host_out", host_out, 4'hC);
        shift_dr(8'h00, got);
        check("R7 R6 inputs captured", got[3:0], 4'hA);
        check("R7 R6 outputs held", got[7:4], 4'hC);
        check("R10 after reshift", host_out, 4'hC);
    endtask

    task automatic t_intest();
        logic [7:0] got;
        load_ir(3'b010);
        check("R8 core_in from stage", core_in, 4'h3);
        check("R8 host_out transparent", host_out, 4'h5);
        shift_dr(8'h5E, got);
        check("R10 shift keeps core_in", core_in, 4'h3);
        pulse_upd();
        check("R8 core_in updated", core_in, 4'hE);
        core_out = 4'h9;
        @(negedge clk);
        pulse_cap();
        shift_dr(8'h00, got);
        check("R8 capture", got, 8'h9E);
    endtask

    task automatic t_preload();
        logic [7:0] got;
        load_ir(3'b011);
        check("R9 R3 core_in", core_in, 4'hA);
        check("R9 R3 host_out", host_out, 4'h9);
        shift_dr(8'h7B, got);
        pulse_upd();
        check("R9 still transparent in", core_in, 4'hA);
        check("R9 still transparent out", host_out, 4'h9);
        pulse_cap();
        shift_dr(8'h7B, got);
        check("R9 capture ignored", got, 8'h7B);
        load_ir(3'b001);
        check("R9 preloaded driven", host_out, 4'h7);
        check("R9 core_in in ext", core_in, 4'hA);
    endtask

    task automatic t_unused();
        logic [7:0] got;
        load_ir(3'b110);
        check("R4 R3 core_in", core_in, host_in);
        check("R4 R3 host_out", host_out, core_out);
        shift_dr(8'b0000_0101, got);
        check("R4 bypass first", got[0], 1'b0);
        check("R4 bypass delay", got[7:1], 7'b000_0101);
    endtask

    task automatic t_priority();
        shift_en = 1'b1; si = 1'b1;
        @(negedge clk);
        check("R11 setup", so, 1'b1);
        capture_en = 1'b1;
        @(negedge clk);
        check("R11 capture wins", so, 1'b0);
        shift_en = 1'b0; capture_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bypass();
        t_extest();
        t_intest();
        t_preload();
        t_unused();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule